// File: doc/BRIEF.md
# Row-Split Weight-Stationary GEMM Engine

This block multiplies a stream of short activation rows by a stationary weight matrix. It is built for matrix products where the activation side has few rows and the reduction and output dimensions are large. The block does not use one large square array. It places several identical square systolic tiles of edge `BLK` side by side, and each tile owns one consecutive slice of `BLK` reduction indices. For each output column, a pipelined adder tree sums the partial results of all tiles.

Weights are loaded in `BLK` beats before rows are streamed in. Each beat writes one row of every tile. A transpose option given at load time writes each tile's slice in transposed order, so the same stored data can serve both a matrix and its transpose. Each activation row enters through a valid/ready handshake. After a fixed pipeline delay, one accumulated result row of `BLK` columns leaves through a second valid/ready handshake. A stall at the output freezes the whole pipeline.

Top module: `kslice_gemm_row`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `y_valid` and `wl_done` are 0, `wl_ready` is 1 and `x_ready` is 0, because no weights are loaded yet.
- R2: A weight load takes `BLK` accepted beats (`wl_valid && wl_ready`). On beat r, tile s element n of `wl_data` is at bits `(s*BLK+n)*DATA_W`. `wl_done` is high for exactly the one cycle after the last beat, and no activation row is accepted between the first beat and that cycle.
- R3: With a normal load, beat r stores element n of tile s as weight W[s*BLK+r][n]. Output column n, taken from bits `n*ACC_W`, equals the signed sum over k of x[k]*W[k][n], where x[k] is taken from bits `k*DATA_W` of `x_data`.
- R4: With `wl_transpose` set during the load, beat r stores element n of tile s as weight W[s*BLK+n][r]. The result rows follow the formula in R3 using that matrix.
- R5: When the output is never stalled, a row accepted in cycle c produces `y_valid` in cycle c + 2*BLK + log2(SUBARRAYS), which is cycle c+10 with the default parameters.
- R6: Result rows leave in the same order in which their rows were accepted.
- R7: While `y_valid` is high and `y_ready` is low, `y_valid` stays high and `y_data` holds its value in the next cycle. No further row is accepted once every pipeline stage is occupied.
- R8: Every accepted row produces exactly one result row. No row is lost and no row is duplicated.
- R9: The accumulator is 2*DATA_W + clog2(SUBARRAYS*BLK) bits wide, so results are exact at the extremes. With all inputs and weights at -128, every column is 262144.
- R10: `wl_ready` is low whenever any accepted row is still in the pipeline, and `x_ready` is low in any cycle in which `wl_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wl_valid | input | 1 | Weight beat offered |
| wl_ready | output | 1 | Weight beat can be taken (pipeline empty) |
| wl_transpose | input | 1 | Write the tiles transposed; sampled on the first beat |
| wl_data | input | SUBARRAYS*BLK*DATA_W | One row for every tile |
| wl_done | output | 1 | One-cycle pulse after the last weight beat |
| x_valid | input | 1 | Activation row offered |
| x_ready | output | 1 | Activation row can be taken |
| x_data | input | SUBARRAYS*BLK*DATA_W | Signed activation row, reduction index k at bits k*DATA_W |
| y_valid | output | 1 | Result row present |
| y_ready | input | 1 | Result row taken |
| y_data | output | BLK*ACC_W | Signed result row, column n at bits n*ACC_W |

## Verification
The hardest case to reach from the ports is a full pipeline held by backpressure, with rows accepted at the front while results wait at the back. In that state, every register stage has to freeze in lock-step, or partial sums from neighbouring rows get mixed. The stimulus reaches it two ways. Long random runs drop `y_ready` about half the time while rows keep arriving. A directed phase holds `y_ready` low with `x_valid` held high, until exactly 2*BLK+log2(SUBARRAYS) rows sit inside, then releases the stall and checks every row. The transposed load is exercised under the same random stall pattern.

// File: rtl/kgemm_pkg.sv
package kgemm_pkg;

  // Width that holds any sum of SUBARRAYS*BLK signed DATA_W x DATA_W products.
  function automatic int acc_width(input int data_w, input int tiles, input int edge_len);
    return 2 * data_w + $clog2(tiles * edge_len);
  endfunction

endpackage

// File: rtl/gemm_pe.sv
module gemm_pe #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              w_we,
  input  logic [DATA_W-1:0] w_in,
  input  logic [DATA_W-1:0] a_in,
  input  logic [ACC_W-1:0]  p_in,
  output logic [ACC_W-1:0]  p_out
);

  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0]        w_q;
  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]         p_d;

  always_comb begin
    prod = $signed(a_in) * $signed(w_q);
    p_d  = p_in + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  end

  // stationary weight
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q <= '0;
    end else if (w_we) begin
      w_q <= w_in;
    end
  end

  // partial sum travelling down the column
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_out <= '0;
    end else if (en) begin
      p_out <= p_d;
    end
  end

endmodule

// File: rtl/gemm_tile.sv
module gemm_tile #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 20,
  parameter int BLK    = 4,
  parameter int RW     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  ld_we,
  input  logic [RW-1:0]         ld_row,
  input  logic                  ld_tr,
  input  logic [BLK*DATA_W-1:0] ld_data,
  input  logic [BLK*DATA_W-1:0] a_vec,
  output logic [BLK*ACC_W-1:0]  psum
);

  localparam int HOPS = BLK - 1;

  logic [BLK*DATA_W-1:0]         sk_out;
  logic [BLK*BLK*DATA_W-1:0]     a_all;
  logic [BLK*HOPS*DATA_W-1:0]    ap_q;
  logic [BLK*HOPS*DATA_W-1:0]    ap_d;
  logic [(BLK+1)*BLK*ACC_W-1:0]  p_flat;

  // input skew: reduction index k is delayed by k cycles
  for (genvar k = 0; k < BLK; k++) begin : g_skew
    if (k == 0) begin : g_direct
      assign sk_out[0 +: DATA_W] = a_vec[0 +: DATA_W];
    end else begin : g_delay
      logic [DATA_W-1:0] sk_q [k];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < k; i++) sk_q[i] <= '0;
        end else if (en) begin
          sk_q[0] <= a_vec[k*DATA_W +: DATA_W];
          for (int i = 1; i < k; i++) sk_q[i] <= sk_q[i-1];
        end
      end
      assign sk_out[k*DATA_W +: DATA_W] = sk_q[k-1];
    end
  end

  // activation values as seen by every PE; column 0 from the skew, others from hop registers
  always_comb begin
    for (int k = 0; k < BLK; k++) begin
      for (int n = 0; n < BLK; n++) begin
        if (n == 0) a_all[(k*BLK+n)*DATA_W +: DATA_W] = sk_out[k*DATA_W +: DATA_W];
        else        a_all[(k*BLK+n)*DATA_W +: DATA_W] = ap_q[(k*HOPS+n-1)*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < BLK; k++) begin
      for (int n = 1; n < BLK; n++) begin
        ap_d[(k*HOPS+n-1)*DATA_W +: DATA_W] = a_all[(k*BLK+n-1)*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_q <= '0;
    end else if (en) begin
      ap_q <= ap_d;
    end
  end

  assign p_flat[0 +: BLK*ACC_W] = '0;

  for (genvar k = 0; k < BLK; k++) begin : g_row
    for (genvar n = 0; n < BLK; n++) begin : g_col
      logic              pe_we;
      logic [DATA_W-1:0] pe_w;
      // normal: beat selects the row; transposed: beat selects the column
      assign pe_we = ld_we & (ld_tr ? (ld_row == RW'(n)) : (ld_row == RW'(k)));
      assign pe_w  = ld_tr ? ld_data[k*DATA_W +: DATA_W] : ld_data[n*DATA_W +: DATA_W];

      gemm_pe #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_pe (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .w_we  (pe_we),
        .w_in  (pe_w),
        .a_in  (a_all[(k*BLK+n)*DATA_W +: DATA_W]),
        .p_in  (p_flat[(k*BLK+n)*ACC_W +: ACC_W]),
        .p_out (p_flat[((k+1)*BLK+n)*ACC_W +: ACC_W])
      );
    end
  end

  // output deskew: column n waits BLK-1-n cycles so a row's columns line up
  for (genvar n = 0; n < BLK; n++) begin : g_deskew
    localparam int DLY = BLK - 1 - n;
    if (DLY == 0) begin : g_direct
      assign psum[n*ACC_W +: ACC_W] = p_flat[(BLK*BLK+n)*ACC_W +: ACC_W];
    end else begin : g_delay
      logic [ACC_W-1:0] dq [DLY];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DLY; i++) dq[i] <= '0;
        end else if (en) begin
          dq[0] <= p_flat[(BLK*BLK+n)*ACC_W +: ACC_W];
          for (int i = 1; i < DLY; i++) dq[i] <= dq[i-1];
        end
      end
      assign psum[n*ACC_W +: ACC_W] = dq[DLY-1];
    end
  end

endmodule

// File: rtl/gemm_sum_tree.sv
module gemm_sum_tree #(
  parameter int ACC_W = 20,
  parameter int BLK   = 4,
  parameter int TILES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic [TILES*BLK*ACC_W-1:0]  parts,
  output logic [BLK*ACC_W-1:0]        total
);

  if (TILES == 1) begin : g_single
    assign total = parts;
  end else begin : g_tree
    // heap numbering: internal nodes 1..TILES-1, leaves TILES..2*TILES-1
    localparam int NODES = TILES - 1;
    logic [NODES*BLK*ACC_W-1:0] nd_q;
    logic [NODES*BLK*ACC_W-1:0] nd_d;
    logic [ACC_W-1:0]           lhs;
    logic [ACC_W-1:0]           rhs;

    always_comb begin
      lhs = '0;
      rhs = '0;
      for (int i = 1; i < TILES; i++) begin
        for (int c = 0; c < BLK; c++) begin
          if (2*i >= TILES) begin
            lhs = parts[((2*i-TILES)*BLK+c)*ACC_W +: ACC_W];
            rhs = parts[((2*i+1-TILES)*BLK+c)*ACC_W +: ACC_W];
          end else begin
            lhs = nd_q[((2*i-1)*BLK+c)*ACC_W +: ACC_W];
            rhs = nd_q[((2*i)*BLK+c)*ACC_W +: ACC_W];
          end
          nd_d[((i-1)*BLK+c)*ACC_W +: ACC_W] = lhs + rhs;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        nd_q <= '0;
      end else if (en) begin
        nd_q <= nd_d;
      end
    end

    assign total = nd_q[0 +: BLK*ACC_W];
  end

endmodule

// File: rtl/kslice_gemm_row.sv
module kslice_gemm_row
  import kgemm_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SUBARRAYS = 4,
  parameter int BLK       = 4
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic                                              wl_valid,
  output logic                                              wl_ready,
  input  logic                                              wl_transpose,
  input  logic [SUBARRAYS*BLK*DATA_W-1:0]                   wl_data,
  output logic                                              wl_done,
  input  logic                                              x_valid,
  output logic                                              x_ready,
  input  logic [SUBARRAYS*BLK*DATA_W-1:0]                   x_data,
  output logic                                              y_valid,
  input  logic                                              y_ready,
  output logic [BLK*acc_width(DATA_W, SUBARRAYS, BLK)-1:0]  y_data
);

  localparam int K_TOT   = SUBARRAYS * BLK;
  localparam int ACC_W   = acc_width(DATA_W, SUBARRAYS, BLK);
  localparam int TREE_LV = $clog2(SUBARRAYS);
  localparam int LAT     = 2 * BLK + TREE_LV;
  localparam int RW      = (BLK > 1) ? $clog2(BLK) : 1;

  // ---------------- pipeline occupancy and stall ----------------
  logic [LAT-1:0] vld_q, vld_d;
  logic           adv;
  logic           x_fire;

  assign adv    = ~vld_q[LAT-1] | y_ready;
  assign x_fire = x_valid & x_ready;

  always_comb begin
    vld_d = {vld_q[LAT-2:0], x_fire};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (adv) begin
      vld_q <= vld_d;
    end
  end

  // ---------------- weight loader ----------------
  logic [RW-1:0] ld_cnt_q, ld_cnt_d;
  logic          ld_tr_q, ld_tr_d;
  logic          loaded_q, loaded_d;
  logic          done_q, done_d;
  logic          wl_beat, ld_first, ld_last, ld_tr_eff;

  assign wl_ready  = ~(|vld_q);
  assign wl_beat   = wl_valid & wl_ready;
  assign ld_first  = (ld_cnt_q == '0);
  assign ld_last   = (ld_cnt_q == RW'(BLK-1));
  assign ld_tr_eff = ld_first ? wl_transpose : ld_tr_q;

  always_comb begin
    ld_cnt_d = ld_cnt_q;
    ld_tr_d  = ld_tr_q;
    loaded_d = loaded_q;
    done_d   = 1'b0;
    if (wl_beat) begin
      ld_cnt_d = ld_last ? '0 : ld_cnt_q + RW'(1);
      loaded_d = ld_last;
      done_d   = ld_last;
      if (ld_first) ld_tr_d = wl_transpose;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_cnt_q <= '0;
      ld_tr_q  <= 1'b0;
      loaded_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      ld_cnt_q <= ld_cnt_d;
      ld_tr_q  <= ld_tr_d;
      loaded_q <= loaded_d;
      done_q   <= done_d;
    end
  end

  assign wl_done = done_q;
  assign x_ready = adv & loaded_q & ~wl_valid;

  // ---------------- datapath ----------------
  logic [K_TOT*DATA_W-1:0]          x_q;
  logic [SUBARRAYS*BLK*ACC_W-1:0]   parts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
    end else if (adv) begin
      x_q <= x_data;
    end
  end

  for (genvar s = 0; s < SUBARRAYS; s++) begin : g_tile
    gemm_tile #(.DATA_W(DATA_W), .ACC_W(ACC_W), .BLK(BLK), .RW(RW)) u_tile (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (adv),
      .ld_we   (wl_beat),
      .ld_row  (ld_cnt_q),
      .ld_tr   (ld_tr_eff),
      .ld_data (wl_data[s*BLK*DATA_W +: BLK*DATA_W]),
      .a_vec   (x_q[s*BLK*DATA_W +: BLK*DATA_W]),
      .psum    (parts[s*BLK*ACC_W +: BLK*ACC_W])
    );
  end

  gemm_sum_tree #(.ACC_W(ACC_W), .BLK(BLK), .TILES(SUBARRAYS)) u_tree (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .parts (parts),
    .total (y_data)
  );

  assign y_valid = vld_q[LAT-1];

endmodule

// File: rtl/kgemm_checks.sv
module kgemm_checks
  import kgemm_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SUBARRAYS = 4,
  parameter int BLK       = 4
) (
  input logic                                              clk,
  input logic                                              rst_n,
  input logic                                              wl_valid,
  input logic                                              wl_ready,
  input logic                                              wl_done,
  input logic                                              x_valid,
  input logic                                              x_ready,
  input logic                                              y_valid,
  input logic                                              y_ready,
  input logic [BLK*acc_width(DATA_W, SUBARRAYS, BLK)-1:0]  y_data
);

  localparam int LAT = 2 * BLK + $clog2(SUBARRAYS);

  logic [7:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_q + 8'(x_valid && x_ready) - 8'(y_valid && y_ready);
    end
  end

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (y_valid && !y_ready) |=> (y_valid && $stable(y_data)));

  a_r10_no_load_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (x_valid && x_ready) |=> !wl_ready);

  a_r10_exclusive_beats: assert property (@(posedge clk) disable iff (!rst_n)
    !(x_valid && x_ready && wl_valid && wl_ready));

  a_r2_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    wl_done |-> $past(wl_valid && wl_ready));

  a_r8_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |-> (pend_q != 8'd0));

  a_r8_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= 8'(LAT));

endmodule

bind kslice_gemm_row kgemm_checks #(
  .DATA_W(DATA_W), .SUBARRAYS(SUBARRAYS), .BLK(BLK)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wl_valid (wl_valid),
  .wl_ready (wl_ready),
  .wl_done  (wl_done),
  .x_valid  (x_valid),
  .x_ready  (x_ready),
  .y_valid  (y_valid),
  .y_ready  (y_ready),
  .y_data   (y_data)
);

// File: tb/sim_kslice_gemm_row.sv
`timescale 1ns/1ps
module sim_kslice_gemm_row;

  localparam int DATA_W = 8;
  localparam int S      = 4;
  localparam int BLK    = 4;
  localparam int K      = S * BLK;
  localparam int ACC_W  = 2 * DATA_W + $clog2(K);
  localparam int LAT    = 2 * BLK + $clog2(S);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                    rst_n;
  logic                    wl_valid, wl_transpose, x_valid, y_ready;
  logic [K*DATA_W-1:0]     wl_data, x_data;
  logic                    wl_ready, wl_done, x_ready, y_valid;
  logic [BLK*ACC_W-1:0]    y_data;

  kslice_gemm_row #(.DATA_W(DATA_W), .SUBARRAYS(S), .BLK(BLK)) u0 (
    .clk(clk), .rst_n(rst_n), .wl_valid(wl_valid), .wl_ready(wl_ready),
    .wl_transpose(wl_transpose), .wl_data(wl_data), .wl_done(wl_done),
    .x_valid(x_valid), .x_ready(x_ready), .x_data(x_data),
    .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int weff [K][BLK];
  logic [BLK*ACC_W-1:0] exp_q [$];
  int acc_q [$];
  int accepted = 0;
  int emitted = 0;
  int beat_idx = 0;
  bit done_exp = 0;
  bit lat_mode = 0;
  bit prev_stall = 0;
  logic [BLK*ACC_W-1:0] prev_y;
  string cur_tag = "R3";

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [BLK*ACC_W-1:0] ref_row(input logic [K*DATA_W-1:0] x);
    logic [BLK*ACC_W-1:0] r;
    for (int n = 0; n < BLK; n++) begin
      longint acc = 0;
      for (int k = 0; k < K; k++)
        acc += longint'($signed(x[k*DATA_W +: DATA_W])) * longint'(weff[k][n]);
      r[n*ACC_W +: ACC_W] = acc[ACC_W-1:0];
    end
    return r;
  endfunction

  function automatic logic [K*DATA_W-1:0] make_vec(input int pat);
    logic [K*DATA_W-1:0] v;
    for (int i = 0; i < K; i++) begin
      case (pat)
        1:       v[i*DATA_W +: DATA_W] = 8'h80;
        2:       v[i*DATA_W +: DATA_W] = 8'h7f;
        default: v[i*DATA_W +: DATA_W] = 8'($urandom);
      endcase
    end
    return v;
  endfunction

  // one cycle: inputs already driven; sample mid-cycle, then move to next negedge
  task automatic step();
    bit done_nxt;
    #1;
    done_nxt = 0;
    if (done_exp || wl_done)
      check(wl_done == done_exp, "R2", "wl_done pulse", wl_done, done_exp);
    if (prev_stall) begin
      check(y_valid == 1'b1, "R7", "y_valid held under stall", y_valid, 1);
      check(y_data == prev_y, "R7", "y_data held under stall", y_data[ACC_W-1:0], prev_y[ACC_W-1:0]);
    end
    if (wl_valid)
      check(x_ready == 1'b0, "R10", "x_ready while wl_valid", x_ready, 0);
    if (wl_valid && wl_ready) begin
      for (int s = 0; s < S; s++)
        for (int n = 0; n < BLK; n++) begin
          int e;
          e = int'($signed(wl_data[(s*BLK+n)*DATA_W +: DATA_W]));
          if (wl_transpose) weff[s*BLK+n][beat_idx] = e;
          else              weff[s*BLK+beat_idx][n] = e;
        end
      done_nxt = (beat_idx == BLK-1);
      beat_idx = (beat_idx + 1) % BLK;
    end
    if (x_valid && x_ready) begin
      exp_q.push_back(ref_row(x_data));
      acc_q.push_back(cyc);
      accepted++;
    end
    if (y_valid && y_ready) begin
      emitted++;
      if (exp_q.size() == 0) begin
        check(0, "R8", "result with no pending row", emitted, accepted);
      end else begin
        logic [BLK*ACC_W-1:0] ev;
        int ac;
        ev = exp_q.pop_front();
        ac = acc_q.pop_front();
        for (int n = 0; n < BLK; n++)
          check(y_data[n*ACC_W +: ACC_W] == ev[n*ACC_W +: ACC_W], cur_tag,
                $sformatf("column %0d (R6 order)", n),
                longint'($signed(y_data[n*ACC_W +: ACC_W])),
                longint'($signed(ev[n*ACC_W +: ACC_W])));
        if (lat_mode)
          check(cyc - ac == LAT, "R5", "latency", cyc - ac, LAT);
      end
    end
    prev_stall = y_valid && !y_ready;
    prev_y     = y_data;
    done_exp   = done_nxt;
    @(negedge clk);
    cyc++;
  endtask

  task automatic drain();
    x_valid = 0;
    y_ready = 1;
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) step();
    check(exp_q.size() == 0, "R8", "rows left after drain", exp_q.size(), 0);
    check(accepted == emitted, "R8", "accepted vs emitted", emitted, accepted);
  endtask

  task automatic load_w(input bit tr, input int pat);
    drain();
    cur_tag = tr ? "R4" : "R3";
    for (int r = 0; r < BLK; r++) begin
      wl_valid     = 1;
      wl_transpose = tr;
      wl_data      = make_vec(pat);
      x_valid      = 1;
      x_data       = make_vec(0);
      step();
    end
    wl_valid = 0;
    x_valid  = 0;
    step();
  endtask

  task automatic stream(input int rows, input int pv, input int pr, input int xpat);
    int target;
    target = accepted + rows;
    for (int i = 0; i < 20000 && accepted < target; i++) begin
      x_valid = (($urandom % 100) < pv);
      x_data  = make_vec(xpat);
      y_ready = (($urandom % 100) < pr);
      step();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd20250911));
    rst_n = 0; wl_valid = 0; wl_transpose = 0; x_valid = 0; y_ready = 1;
    wl_data = '0; x_data = '0;
    repeat (3) @(negedge clk);
    #1;
    check(y_valid == 0 && wl_done == 0, "R1", "outputs in reset", y_valid, 0);
    check(wl_ready == 1 && x_ready == 0, "R1", "ready flags in reset", x_ready, 0);
    rst_n = 1;
    @(negedge clk);
    #1;
    check(y_valid == 0 && wl_done == 0 && wl_ready == 1, "R1", "after release", y_valid, 0);
    check(x_ready == 0, "R1", "no rows before weights", x_ready, 0);
    @(negedge clk);

    // normal load, latency and back-to-back order
    load_w(0, 0);
    lat_mode = 1;
    x_valid = 1; x_data = make_vec(0); y_ready = 1;
    step();
    x_valid = 0;
    check(wl_ready == 0, "R10", "wl_ready with row in flight", wl_ready, 0);
    drain();
    for (int i = 0; i < 3; i++) begin
      x_valid = 1; x_data = make_vec(0); step();
    end
    drain();
    lat_mode = 0;

    // random stalls, normal weights
    stream(60, 70, 50, 0);
    drain();

    // full pipeline under a long stall
    base = accepted;
    y_ready = 0;
    for (int i = 0; i < 3 * LAT; i++) begin
      x_valid = 1; x_data = make_vec(0); step();
    end
    check(accepted - base == LAT, "R7", "rows taken while stalled", accepted - base, LAT);
    drain();

    // extremes
    load_w(0, 1);
    stream(4, 100, 100, 1);
    drain();
    check(emitted == accepted, "R9", "extreme rows drained", emitted, accepted);
    load_w(0, 2);
    stream(4, 100, 60, 1);
    drain();

    // transposed weights
    load_w(1, 0);
    stream(60, 70, 50, 0);
    drain();
    lat_mode = 1;
    x_valid = 1; x_data = make_vec(0); y_ready = 1; step();
    drain();
    lat_mode = 0;

    // back to normal after a transposed load
    load_w(0, 0);
    stream(40, 90, 80, 0);
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule